// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block brings an 8-bit processor core out of reset and carries out interrupt entry on its behalf. Coming out of reset, it fetches the start address from the reset vector and hands the core a fresh status byte. After that it is asked before every opcode fetch whether an interrupt has to be entered first. It watches three kinds of request. The first is a non-maskable request latched from a pulse. The second is a one-shot maskable request latched from a pulse. The third is a bank of independent maskable sources that stay asserted until their owner releases them.

When the sequencer enters an interrupt it pushes the return address and the status byte through a stack-write port. It then reads the two vector bytes through a registered vector-read port. Finally it hands the core a new PC, status and stack pointer, and reports the cycle cost of the entry. The core is the instruction executor, and it holds PC, status and stack pointer between entries. Stack storage and vector storage sit outside the block. A core that has entered the halted state gets no interrupt entries until it is reset.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset is released, the block reads address 0xFFFC and then address 0xFFFD. It loads PC = {byte@0xFFFD, byte@0xFFFC} and status = 0x04, with no stack write and no cost report. Reset also clears the halted state and every pending request.
- R2: When `fetch_req` arrives with nothing to enter, `fetch_go` pulses on the next cycle and there is no stack write, no vector read and no PC load.
- R3: When the non-maskable request is pending, it is entered in preference to any maskable request. Its vector comes from 0xFFFA/0xFFFB. The loaded status is the pre-entry status with bit 4 (B) cleared and bit 2 (I) unchanged.
- R4: A maskable request is entered only if status bit 2 (I) was clear in the status captured at the previous grant, meaning the value before the previous instruction ran. Its vector comes from 0xFFFE/0xFFFF, and the loaded status has bit 2 set and bit 4 cleared.
- R5: Entry writes three bytes, in this order: PC[15:8] to 0x0100+S, PC[7:0] to 0x0100+S-1, and the status with bit 4 cleared and bit 5 set to 0x0100+S-2. The returned S is S-3. All S arithmetic wraps modulo 256.
- R6: Each entry reports `cost` = 7 in a one-cycle `cost_valid` pulse. The pulse coincides with the PC load and the `fetch_go` pulse. From `fetch_req` to `fetch_go`, an entry takes 7 cycles.
- R7: After a `jam_stb` pulse, no interrupt of either kind is entered, and every fetch is granted at once. This lasts until reset.
- R8: At any check where a request is pending, the non-maskable and one-shot bits are cleared, even if nothing is entered. Source bits stay set until they are cleared.
- R9: `src_set_stb` sets the source bits selected by `src_mask`, and `src_clr_stb` clears them. If a bit is both set and cleared in the same cycle, the clear wins.
- R10: A non-maskable pulse that arrives while an entry is in progress stays pending and is entered at the next check.
- R11: The two vector bytes are read low byte first, on consecutive addresses and in consecutive cycles. A stack write and a vector read never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set_stb | input | 1 | Set the source bits selected by src_mask |
| src_clr_stb | input | 1 | Clear the source bits selected by src_mask |
| src_mask | input | NSRC | Source select for the set and clear strobes |
| oneshot_stb | input | 1 | Latch a one-shot maskable request |
| nmi_stb | input | 1 | Latch a non-maskable request |
| jam_stb | input | 1 | Core has halted; block entries until reset |
| fetch_req | input | 1 | Core is about to fetch an opcode |
| status_in | input | 8 | Core status byte |
| pc_in | input | 16 | Core PC (return address) |
| sp_in | input | 8 | Core stack pointer |
| vec_rdata | input | 8 | Vector byte, one cycle after the read is registered |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| vec_re | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector read address |
| pc_out | output | 16 | New PC |
| pc_load | output | 1 | Load pc_out into the core |
| status_out | output | 8 | New status byte |
| status_load | output | 1 | Load status_out into the core |
| sp_out | output | 8 | New stack pointer |
| sp_load | output | 1 | Load sp_out into the core |
| fetch_go | output | 1 | Core may fetch now |
| cost_valid | output | 1 | Entry cycle cost is valid |
| cost | output | 4 | Entry cycle cost |

## Verification
The assertions are checked on every cycle and cover the shape of the traffic. Every stack write lands on the stack page. Consecutive pushes step downward, and the third push carries bit 5 set and bit 4 clear. Vector reads step upward, and stack and vector traffic never overlap. Every cost pulse is single and arrives together with the PC and stack-pointer loads.

Some behaviour depends on history, and only the directed scenarios show it. These scenarios cover the following:
- the one-instruction delay on the disable flag;
- non-maskable priority;
- the dropping of a masked one-shot request;
- the clear-wins rule for sources;
- a request that arrives mid-entry;
- the halted state;
- the exact vector, PC, status and stack values.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_P,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_VEC_CAP,
    ST_VEC_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    EK_RESET,
    EK_NMI,
    EK_IRQ
  } entry_kind_e;

  // status bit positions the core decodes
  localparam int unsigned SB_DISABLE = 2;
  localparam int unsigned SB_BRK     = 4;
  localparam int unsigned SB_ONE     = 5;

endpackage

// File: rtl/irq_entry_reqs.sv
module irq_entry_reqs #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src_set_stb,
  input  logic            src_clr_stb,
  input  logic [NSRC-1:0] src_mask,
  input  logic            oneshot_stb,
  input  logic            nmi_stb,
  input  logic            drop_stb,
  output logic            nmi_pend,
  output logic            mask_pend,
  output logic            any_pend
);

  logic [NSRC-1:0] src_q;
  logic            oneshot_q;
  logic            nmi_q;

  // one flop per source; clear applied after set so clear wins
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        src_q[g] <= 1'b0;
      end else begin
        if (src_clr_stb && src_mask[g]) begin
          src_q[g] <= 1'b0;
        end else if (src_set_stb && src_mask[g]) begin
          src_q[g] <= 1'b1;
        end
      end
    end
  end

  // a fresh pulse survives a drop in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q     <= 1'b0;
      oneshot_q <= 1'b0;
    end else begin
      nmi_q     <= (nmi_q && !drop_stb) || nmi_stb;
      oneshot_q <= (oneshot_q && !drop_stb) || oneshot_stb;
    end
  end

  assign nmi_pend  = nmi_q;
  assign mask_pend = oneshot_q || (|src_q);
  assign any_pend  = nmi_pend || mask_pend;

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int unsigned    ADDR_W       = 16,
  parameter int unsigned    DATA_W       = 8,
  parameter int unsigned    COST_W       = 4,
  parameter int unsigned    ENTRY_CYCLES = 7,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI   = 'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST   = 'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ   = 'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jam_stb,
  input  logic              fetch_req,
  input  logic [DATA_W-1:0] status_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] vec_rdata,
  input  logic              nmi_pend,
  input  logic              mask_pend,
  input  logic              any_pend,
  output logic              drop_stb,
  output logic              stk_we,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [DATA_W-1:0] stk_wdata,
  output logic              vec_re,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_load,
  output logic [DATA_W-1:0] status_out,
  output logic              status_load,
  output logic [DATA_W-1:0] sp_out,
  output logic              sp_load,
  output logic              fetch_go,
  output logic              cost_valid,
  output logic [COST_W-1:0] cost
);

  localparam logic [DATA_W-1:0] DISABLE_M = DATA_W'(1) << SB_DISABLE;
  localparam logic [DATA_W-1:0] BRK_M     = DATA_W'(1) << SB_BRK;
  localparam logic [DATA_W-1:0] ONE_M     = DATA_W'(1) << SB_ONE;

  seq_state_e        state_q;
  entry_kind_e       kind_q;
  logic              halted_q;
  logic              prev_dis_q;
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] p_q;
  logic [ADDR_W-1:0] ret_q;
  logic [DATA_W-1:0] lo_q;

  logic              check;
  logic              take_nmi;
  logic              take_irq;
  logic [ADDR_W-1:0] vec_base;
  logic [DATA_W-1:0] status_fin;

  assign check    = (state_q == ST_IDLE) && fetch_req;
  assign drop_stb = check && any_pend;
  assign take_nmi = check && !halted_q && nmi_pend;
  assign take_irq = check && !halted_q && !nmi_pend && mask_pend && !prev_dis_q;

  always_comb begin
    case (kind_q)
      EK_NMI:  vec_base = VEC_NMI;
      EK_IRQ:  vec_base = VEC_IRQ;
      default: vec_base = VEC_RST;
    endcase
    if (kind_q == EK_RESET) begin
      status_fin = DISABLE_M;
    end else if (kind_q == EK_IRQ) begin
      status_fin = (p_q & ~BRK_M) | DISABLE_M;
    end else begin
      status_fin = p_q & ~BRK_M;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_VEC_LO;
      kind_q      <= EK_RESET;
      halted_q    <= 1'b0;
      prev_dis_q  <= 1'b1;
      sp_q        <= '0;
      p_q         <= '0;
      ret_q       <= '0;
      lo_q        <= '0;
      stk_we      <= 1'b0;
      stk_addr    <= '0;
      stk_wdata   <= '0;
      vec_re      <= 1'b0;
      vec_addr    <= '0;
      pc_out      <= '0;
      pc_load     <= 1'b0;
      status_out  <= '0;
      status_load <= 1'b0;
      sp_out      <= '0;
      sp_load     <= 1'b0;
      fetch_go    <= 1'b0;
      cost_valid  <= 1'b0;
      cost        <= '0;
    end else begin
      stk_we      <= 1'b0;
      pc_load     <= 1'b0;
      status_load <= 1'b0;
      sp_load     <= 1'b0;
      fetch_go    <= 1'b0;
      cost_valid  <= 1'b0;
      if (jam_stb) begin
        halted_q <= 1'b1;
      end
      case (state_q)
        ST_IDLE: begin
          if (take_nmi || take_irq) begin
            kind_q    <= take_nmi ? EK_NMI : EK_IRQ;
            p_q       <= status_in;
            ret_q     <= pc_in;
            stk_we    <= 1'b1;
            stk_addr  <= {STACK_PAGE, sp_in};
            stk_wdata <= pc_in[ADDR_W-1:DATA_W];
            sp_q      <= sp_in - 1'b1;
            state_q   <= ST_PUSH_LO;
          end else if (check) begin
            fetch_go   <= 1'b1;
            prev_dis_q <= status_in[SB_DISABLE];
          end
        end
        ST_PUSH_LO: begin
          stk_we    <= 1'b1;
          stk_addr  <= {STACK_PAGE, sp_q};
          stk_wdata <= ret_q[DATA_W-1:0];
          sp_q      <= sp_q - 1'b1;
          state_q   <= ST_PUSH_P;
        end
        ST_PUSH_P: begin
          stk_we    <= 1'b1;
          stk_addr  <= {STACK_PAGE, sp_q};
          stk_wdata <= (p_q & ~BRK_M) | ONE_M;
          sp_q      <= sp_q - 1'b1;
          state_q   <= ST_VEC_LO;
        end
        ST_VEC_LO: begin
          vec_re   <= 1'b1;
          vec_addr <= vec_base;
          state_q  <= ST_VEC_HI;
        end
        ST_VEC_HI: begin
          vec_addr <= vec_base + 1'b1;
          state_q  <= ST_VEC_CAP;
        end
        ST_VEC_CAP: begin
          vec_re  <= 1'b0;
          lo_q    <= vec_rdata;
          state_q <= ST_VEC_FIN;
        end
        ST_VEC_FIN: begin
          pc_out      <= {vec_rdata, lo_q};
          pc_load     <= 1'b1;
          status_out  <= status_fin;
          status_load <= 1'b1;
          prev_dis_q  <= status_fin[SB_DISABLE];
          if (kind_q != EK_RESET) begin
            sp_out     <= sp_q;
            sp_load    <= 1'b1;
            cost_valid <= 1'b1;
            cost       <= COST_W'(ENTRY_CYCLES);
            fetch_go   <= 1'b1;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int unsigned NSRC         = 4,
  parameter int unsigned COST_W       = 4,
  parameter int unsigned ENTRY_CYCLES = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src_set_stb,
  input  logic            src_clr_stb,
  input  logic [NSRC-1:0] src_mask,
  input  logic            oneshot_stb,
  input  logic            nmi_stb,
  input  logic            jam_stb,
  input  logic            fetch_req,
  input  logic [7:0]      status_in,
  input  logic [15:0]     pc_in,
  input  logic [7:0]      sp_in,
  input  logic [7:0]      vec_rdata,
  output logic            stk_we,
  output logic [15:0]     stk_addr,
  output logic [7:0]      stk_wdata,
  output logic            vec_re,
  output logic [15:0]     vec_addr,
  output logic [15:0]     pc_out,
  output logic            pc_load,
  output logic [7:0]      status_out,
  output logic            status_load,
  output logic [7:0]      sp_out,
  output logic            sp_load,
  output logic            fetch_go,
  output logic            cost_valid,
  output logic [COST_W-1:0] cost
);

  logic nmi_pend;
  logic mask_pend;
  logic any_pend;
  logic drop_stb;

  irq_entry_reqs #(.NSRC(NSRC)) u_reqs (
    .clk         (clk),
    .rst         (rst),
    .src_set_stb (src_set_stb),
    .src_clr_stb (src_clr_stb),
    .src_mask    (src_mask),
    .oneshot_stb (oneshot_stb),
    .nmi_stb     (nmi_stb),
    .drop_stb    (drop_stb),
    .nmi_pend    (nmi_pend),
    .mask_pend   (mask_pend),
    .any_pend    (any_pend)
  );

  irq_entry_fsm #(
    .ADDR_W       (16),
    .DATA_W       (8),
    .COST_W       (COST_W),
    .ENTRY_CYCLES (ENTRY_CYCLES)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .jam_stb     (jam_stb),
    .fetch_req   (fetch_req),
    .status_in   (status_in),
    .pc_in       (pc_in),
    .sp_in       (sp_in),
    .vec_rdata   (vec_rdata),
    .nmi_pend    (nmi_pend),
    .mask_pend   (mask_pend),
    .any_pend    (any_pend),
    .drop_stb    (drop_stb),
    .stk_we      (stk_we),
    .stk_addr    (stk_addr),
    .stk_wdata   (stk_wdata),
    .vec_re      (vec_re),
    .vec_addr    (vec_addr),
    .pc_out      (pc_out),
    .pc_load     (pc_load),
    .status_out  (status_out),
    .status_load (status_load),
    .sp_out      (sp_out),
    .sp_load     (sp_load),
    .fetch_go    (fetch_go),
    .cost_valid  (cost_valid),
    .cost        (cost)
  );

endmodule

// File: rtl/irq_entry_checker.sv
module irq_entry_checker #(
  parameter int unsigned COST_W       = 4,
  parameter int unsigned ENTRY_CYCLES = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              stk_we,
  input logic [15:0]       stk_addr,
  input logic [7:0]        stk_wdata,
  input logic              vec_re,
  input logic [15:0]       vec_addr,
  input logic              pc_load,
  input logic              sp_load,
  input logic              fetch_go,
  input logic              cost_valid,
  input logic [COST_W-1:0] cost
);

  a_r5_stack_page: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> stk_addr[15:8] == 8'h01);

  a_r5_push_descends: assert property (@(posedge clk) disable iff (rst)
    (stk_we && $past(stk_we)) |-> stk_addr[7:0] == 8'($past(stk_addr[7:0]) - 8'd1));

  a_r5_status_image: assert property (@(posedge clk) disable iff (rst)
    (stk_we && $past(stk_we) && $past(stk_we, 2)) |-> (stk_wdata[5] && !stk_wdata[4]));

  a_r11_vec_ascends: assert property (@(posedge clk) disable iff (rst)
    (vec_re && $past(vec_re)) |-> vec_addr == 16'($past(vec_addr) + 16'd1));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(stk_we && vec_re));

  a_r6_cost_with_load: assert property (@(posedge clk) disable iff (rst)
    cost_valid |-> (pc_load && sp_load && fetch_go && cost == COST_W'(ENTRY_CYCLES)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cost_valid |=> !cost_valid);

  a_r2_grant_quiet: assert property (@(posedge clk) disable iff (rst)
    fetch_go |-> (!stk_we && !vec_re));

endmodule

bind irq_entry_seq irq_entry_checker #(
  .COST_W       (COST_W),
  .ENTRY_CYCLES (ENTRY_CYCLES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stk_we     (stk_we),
  .stk_addr   (stk_addr),
  .stk_wdata  (stk_wdata),
  .vec_re     (vec_re),
  .vec_addr   (vec_addr),
  .pc_load    (pc_load),
  .sp_load    (sp_load),
  .fetch_go   (fetch_go),
  .cost_valid (cost_valid),
  .cost       (cost)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_set_stb = 1'b0;
  logic        src_clr_stb = 1'b0;
  logic [3:0]  src_mask = '0;
  logic        oneshot_stb = 1'b0;
  logic        nmi_stb = 1'b0;
  logic        jam_stb = 1'b0;
  logic        fetch_req = 1'b0;
  logic [7:0]  status_in = 8'h04;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  sp_in = 8'hFD;
  logic [7:0]  vec_rdata = 8'h00;
  logic        stk_we;
  logic [15:0] stk_addr;
  logic [7:0]  stk_wdata;
  logic        vec_re;
  logic [15:0] vec_addr;
  logic [15:0] pc_out;
  logic        pc_load;
  logic [7:0]  status_out;
  logic        status_load;
  logic [7:0]  sp_out;
  logic        sp_load;
  logic        fetch_go;
  logic        cost_valid;
  logic [3:0]  cost;

  always #10 clk = ~clk;

  irq_entry_seq dut (.*);

  // vector storage with one-cycle read latency
  function automatic logic [7:0] vec_byte(input logic [15:0] a);
    case (a)
      16'hFFFA: vec_byte = 8'h34;
      16'hFFFB: vec_byte = 8'h12;
      16'hFFFC: vec_byte = 8'h00;
      16'hFFFD: vec_byte = 8'h80;
      16'hFFFE: vec_byte = 8'hCD;
      16'hFFFF: vec_byte = 8'hAB;
      default:  vec_byte = 8'hEE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (vec_re) vec_rdata <= vec_byte(vec_addr);
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int          n_wr, n_vec, n_load, n_cost;
  logic [15:0] wr_addr [8];
  logic [7:0]  wr_data [8];
  logic [15:0] vec_log [8];
  logic [15:0] ld_pc;
  logic [7:0]  ld_st, ld_sp;
  logic [3:0]  ld_cost;

  always @(negedge clk) begin
    if (!rst) begin
      if (stk_we) begin
        if (n_wr < 8) begin wr_addr[n_wr] = stk_addr; wr_data[n_wr] = stk_wdata; end
        n_wr++;
      end
      if (vec_re) begin
        if (n_vec < 8) vec_log[n_vec] = vec_addr;
        n_vec++;
      end
      if (pc_load) begin n_load++; ld_pc = pc_out; ld_st = status_out; end
      if (sp_load) ld_sp = sp_out;
      if (cost_valid) begin n_cost++; ld_cost = cost; end
    end
  end

  task automatic clear_logs();
    n_wr = 0; n_vec = 0; n_load = 0; n_cost = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one opcode-fetch request; returns cycles until the grant
  task automatic do_fetch(output int cyc);
    clear_logs();
    @(negedge clk) fetch_req = 1'b1;
    @(negedge clk) fetch_req = 1'b0;
    cyc = 1;
    while (!fetch_go && cyc < 30) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
  endtask

  task automatic pulse_nmi();
    @(negedge clk) nmi_stb = 1'b1;
    @(negedge clk) nmi_stb = 1'b0;
  endtask

  task automatic pulse_oneshot();
    @(negedge clk) oneshot_stb = 1'b1;
    @(negedge clk) oneshot_stb = 1'b0;
  endtask

  task automatic src_op(input bit set, input bit clr, input logic [3:0] m);
    @(negedge clk);
    src_set_stb = set; src_clr_stb = clr; src_mask = m;
    @(negedge clk);
    src_set_stb = 0; src_clr_stb = 0; src_mask = '0;
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    clear_logs();
    rst = 1'b0;
    for (int i = 0; i < 20 && n_load == 0; i++) @(negedge clk);
    @(negedge clk);
    chk("R1 reset pc", ld_pc, 16'h8000);
    chk("R1 reset status", ld_st, 8'h04);
    chk("R1 reset no stack write", n_wr, 0);
    chk("R1 reset no cost", n_cost, 0);
    chk("R11 reset vec low first", vec_log[0], 16'hFFFC);
    chk("R11 reset vec high second", vec_log[1], 16'hFFFD);
    status_in = 8'h04;
  endtask

  task automatic t_plain();
    int c;
    status_in = 8'h00;
    do_fetch(c);
    chk("R2 grant next cycle", c, 1);
    chk("R2 no stack write", n_wr, 0);
    chk("R2 no pc load", n_load, 0);
  endtask

  task automatic t_nmi_priority();
    int c;
    src_op(1, 0, 4'b0001);
    pulse_nmi();
    status_in = 8'h10; pc_in = 16'hC123; sp_in = 8'hFD;
    do_fetch(c);
    chk("R3 nmi vector", vec_log[0], 16'hFFFA);
    chk("R3 nmi pc", ld_pc, 16'h1234);
    chk("R3 nmi status B clear I kept", ld_st, 8'h00);
    chk("R5 push count", n_wr, 3);
    chk("R5 push hi addr", wr_addr[0], 16'h01FD);
    chk("R5 push hi data", wr_data[0], 8'hC1);
    chk("R5 push lo addr", wr_addr[1], 16'h01FC);
    chk("R5 push lo data", wr_data[1], 8'h23);
    chk("R5 push status", {wr_addr[2], wr_data[2]}, {16'h01FB, 8'h20});
    chk("R5 sp out", ld_sp, 8'hFA);
    chk("R6 cost count", n_cost, 1);
    chk("R6 cost value", ld_cost, 7);
    chk("R6 entry latency", c, 7);
    status_in = ld_st; sp_in = ld_sp; pc_in = ld_pc;
  endtask

  task automatic t_irq_and_delay();
    int c;
    do_fetch(c);
    chk("R4 irq vector", vec_log[0], 16'hFFFE);
    chk("R4 irq pc", ld_pc, 16'hABCD);
    chk("R4 irq status sets I", ld_st, 8'h04);
    chk("R4 irq pushed status", wr_data[2], 8'h20);
    status_in = 8'h04;
    do_fetch(c);
    chk("R4 masked while I set", n_load, 0);
    status_in = 8'h00;
    do_fetch(c);
    chk("R4 mask uses previous status", n_load, 0);
    do_fetch(c);
    chk("R4 taken once previous I clear", vec_log[0], 16'hFFFE);
    chk("R8 source stays set", n_load, 1);
    status_in = 8'h04;
    src_op(0, 1, 4'b0001);
    status_in = 8'h00;
    do_fetch(c);
    do_fetch(c);
    chk("R8 cleared source not entered", n_load, 0);
  endtask

  task automatic t_oneshot();
    int c;
    status_in = 8'h04;
    do_fetch(c);
    pulse_oneshot();
    do_fetch(c);
    chk("R8 masked oneshot not entered", n_load, 0);
    status_in = 8'h00;
    do_fetch(c);
    do_fetch(c);
    chk("R8 masked oneshot dropped", n_load, 0);
    pulse_oneshot();
    do_fetch(c);
    chk("R8 oneshot entered", vec_log[0], 16'hFFFE);
    status_in = 8'h00;
    do_fetch(c);
    do_fetch(c);
    chk("R8 oneshot cleared after entry", n_load, 0);
  endtask

  task automatic t_set_clr();
    int c;
    src_op(1, 1, 4'b0010);
    do_fetch(c);
    chk("R9 clear wins same cycle", n_load, 0);
    src_op(1, 0, 4'b1100);
    src_op(0, 1, 4'b0100);
    do_fetch(c);
    chk("R9 remaining source entered", vec_log[0], 16'hFFFE);
    src_op(0, 1, 4'b1000);
    status_in = 8'h00;
    do_fetch(c);
    do_fetch(c);
    chk("R9 all sources cleared", n_load, 0);
  endtask

  task automatic t_wrap();
    int c;
    pulse_nmi();
    status_in = 8'h04; sp_in = 8'h01; pc_in = 16'h5A6B;
    do_fetch(c);
    chk("R5 wrap hi", {wr_addr[0], wr_data[0]}, {16'h0101, 8'h5A});
    chk("R5 wrap lo", {wr_addr[1], wr_data[1]}, {16'h0100, 8'h6B});
    chk("R5 wrap status", {wr_addr[2], wr_data[2]}, {16'h01FF, 8'h24});
    chk("R5 wrap sp", ld_sp, 8'hFE);
    chk("R3 nmi ignores I", ld_pc, 16'h1234);
    sp_in = 8'hFD;
  endtask

  task automatic t_nmi_midway();
    int c;
    pulse_nmi();
    clear_logs();
    @(negedge clk) fetch_req = 1'b1;
    @(negedge clk) fetch_req = 1'b0;
    @(negedge clk) nmi_stb = 1'b1;
    @(negedge clk) nmi_stb = 1'b0;
    for (int i = 0; i < 20 && !fetch_go; i++) @(negedge clk);
    @(negedge clk);
    chk("R10 first entry", n_load, 1);
    do_fetch(c);
    chk("R10 late nmi entered", vec_log[0], 16'hFFFA);
    do_fetch(c);
    chk("R10 entered once", n_load, 0);
  endtask

  task automatic t_halt();
    int c;
    @(negedge clk) jam_stb = 1'b1;
    @(negedge clk) jam_stb = 1'b0;
    pulse_nmi();
    do_fetch(c);
    chk("R7 halted nmi ignored", n_load, 0);
    chk("R7 halted grant at once", c, 1);
    src_op(1, 0, 4'b0001);
    status_in = 8'h00;
    do_fetch(c);
    do_fetch(c);
    chk("R7 halted irq ignored", n_wr, 0);
    src_op(0, 1, 4'b0001);
    pulse_nmi();
    t_reset();
    status_in = 8'h00;
    do_fetch(c);
    chk("R1 reset clears pending nmi", n_load, 0);
    pulse_nmi();
    do_fetch(c);
    chk("R7 reset clears halted", vec_log[0], 16'hFFFA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_nmi_priority();
    t_irq_and_delay();
    t_oneshot();
    t_set_clr();
    t_wrap();
    t_nmi_midway();
    t_halt();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule